// File: doc/BRIEF.md
# Hot-plug slot connection sequencer

This block brings an isolated card on a parallel PCI-style slot back onto the bus in timed steps. While the slot is isolated, every slot pin the block controls is actively held low. After the power controller reports power good, the block raises three internal enables one after another: clock enable, bus enable and reset release. Each step waits for a delay taken from a count input, which is loaded when the step begins. A configuration input can swap the first two steps so that the bus is enabled before the clock.

The enables are turned into per-group pin controls for the pad ring. The slot clock outputs are released to toggle. The address/data group returns to normal drive. The framing/ready, grant and error groups are driven high for one clock and then tri-stated. The interrupt and wake pins are tri-stated at once. The slot reset pin goes high last. Until reset is released, any outbound transaction request aimed at the slot is answered with an internal master abort instead of being forwarded. A disconnect request returns the slot to isolation on the next clock, from any state.

Top module: `hp_slot_seq`

## Requirements
- R1: After reset, and whenever the slot is isolated, these controls hold: clk_low_o[i]=1 for every software-enabled clock output i<6, ad_hold_o=1, sus_oe_o=3'b111 with sus_val_o=3'b000, irq_oe_o=1, pme_oe_o=1 and rst_val_o=0.
- R2: Power good on its own changes no pin control. The pins stay as in R1 until the first step delay has run out.
- R3: With swap_order_i=0, the power-good level is sampled at clock edge E0. Clock enable then takes effect after edge E0+d1+1, bus enable after E0+d1+d2+2 and reset release after E0+d1+d2+d3+3, where d1, d2 and d3 are the values on dly_step1_i, dly_step2_i and dly_step3_i when each step starts.
- R4: With swap_order_i=1 at E0, bus enable takes the first step slot and clock enable takes the second, with the same timing as R3.
- R5: A clock output i<6 with clk_sw_en_i[i]=1 has clk_low_o[i]=1 until clock enable and 0 after it. With clk_sw_en_i[i]=0 it has clk_high_o[i]=1 and clk_low_o[i]=0 at all times. Output 6 (the feedback clock) always has clk_low_o[6]=0 and clk_high_o[6]=0.
- R6: For each sustained group (bit 0 control, bit 1 grant, bit 2 error), sus_val_o equals the bus enable. sus_oe_o is 1 in the first cycle of bus enable and 0 from the next cycle on, so the group is driven high for exactly one clock.
- R7: The address/data group is released (ad_hold_o=0) in the same cycle that bus enable takes effect.
- R8: irq_oe_o and pme_oe_o fall to 0 in the cycle that bus enable takes effect, with no high-drive cycle.
- R9: rst_val_o stays 0 through the bus-enable step and is 1 from reset release on, for as long as the slot stays connected.
- R10: In the same cycle as tx_req_i, the block asserts tx_abort_o if reset has not been released and tx_fwd_o if it has. Both outputs are 0 when there is no request.
- R11: A disconnect request in any state gives the R1 pin state at the next clock. While the request is held it keeps the slot isolated even when power good is high.
- R12: swap_order_i is sampled only when a sequence starts. Changing it in the middle of a sequence has no effect on the step order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_good_i | input | 1 | Slot power is applied and stable |
| disc_req_i | input | 1 | Disconnect request, returns the slot to isolation |
| swap_order_i | input | 1 | 1: bus enable before clock enable |
| dly_step1_i | input | DLY_W | Delay count for the first step |
| dly_step2_i | input | DLY_W | Delay count for the second step |
| dly_step3_i | input | DLY_W | Delay count for reset release |
| clk_sw_en_i | input | NCLK-1 | Software enable for each driven slot clock output |
| tx_req_i | input | 1 | Outbound transaction aimed at the slot |
| tx_fwd_o | output | 1 | Forward the transaction to the slot |
| tx_abort_o | output | 1 | Master-abort the transaction internally |
| clk_low_o | output | NCLK | Force the slot clock output low |
| clk_high_o | output | NCLK | Force the slot clock output high |
| ad_hold_o | output | 1 | Hold the address/data/parity/64-bit group low |
| sus_oe_o | output | NSUS | Output enable of the sustained groups |
| sus_val_o | output | NSUS | Drive value of the sustained groups |
| irq_oe_o | output | 1 | Interrupt pins driven (low) when 1 |
| pme_oe_o | output | 1 | Wake pin driven (low) when 1 |
| rst_val_o | output | 1 | Slot reset pin value |

## Verification
A disconnect can arrive in the same cycle that a step delay runs out. In that cycle the disconnect must win: the enable never becomes visible, and the pins are isolated at the next clock. The bench issues disconnects at the exact expiry cycle of each step, one cycle before it, and well after reset release, and compares every pin control against a bench-computed model each cycle. A transaction request can also coincide with reset release, so requests are driven at random in every cycle of each sequence. The bench checks that the abort turns into a forward exactly in the cycle the reset pin goes high.

// File: rtl/hp_slot_pkg.sv
package hp_slot_pkg;
  typedef enum logic [2:0] {
    S_ISO   = 3'd0,
    S_STEP1 = 3'd1,
    S_STEP2 = 3'd2,
    S_STEP3 = 3'd3,
    S_LIVE  = 3'd4
  } seq_state_e;

  typedef struct packed {
    logic clk_en;
    logic bus_en;
    logic rst_rel;
  } slot_en_t;
endpackage

// File: rtl/hp_dly_cnt.sv
module hp_dly_cnt #(
  parameter int DLY_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [DLY_W-1:0] load_val_i,
  output logic             zero_o
);
  logic [DLY_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // R3: an expired count stays expired until reloaded
  a_r3_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero_o && !load_i) |=> zero_o);
endmodule

// File: rtl/hp_seq_fsm.sv
module hp_seq_fsm
  import hp_slot_pkg::*;
#(
  parameter int DLY_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pwr_good_i,
  input  logic             disc_req_i,
  input  logic             swap_order_i,
  input  logic [DLY_W-1:0] dly_step1_i,
  input  logic [DLY_W-1:0] dly_step2_i,
  input  logic [DLY_W-1:0] dly_step3_i,
  output slot_en_t         en_o
);
  seq_state_e       state_q, state_d;
  logic             step1_q, step2_q, rel_q;
  logic             swap_q;
  logic             ld;
  logic [DLY_W-1:0] ld_val;
  logic             zero;

  hp_dly_cnt #(.DLY_W(DLY_W)) i_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (ld),
    .load_val_i (ld_val),
    .zero_o     (zero)
  );

  always_comb begin
    state_d = state_q;
    ld      = 1'b0;
    ld_val  = dly_step1_i;
    if (disc_req_i) begin
      state_d = S_ISO;
    end else begin
      unique case (state_q)
        S_ISO:   if (pwr_good_i) begin
                   state_d = S_STEP1; ld = 1'b1; ld_val = dly_step1_i;
                 end
        S_STEP1: if (zero) begin
                   state_d = S_STEP2; ld = 1'b1; ld_val = dly_step2_i;
                 end
        S_STEP2: if (zero) begin
                   state_d = S_STEP3; ld = 1'b1; ld_val = dly_step3_i;
                 end
        S_STEP3: if (zero) state_d = S_LIVE;
        default: state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_ISO;
      step1_q <= 1'b0;
      step2_q <= 1'b0;
      rel_q   <= 1'b0;
      swap_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (disc_req_i) begin
        step1_q <= 1'b0;
        step2_q <= 1'b0;
        rel_q   <= 1'b0;
      end else begin
        if (state_q == S_ISO && pwr_good_i) swap_q  <= swap_order_i;
        if (state_q == S_STEP1 && zero)     step1_q <= 1'b1;
        if (state_q == S_STEP2 && zero)     step2_q <= 1'b1;
        if (state_q == S_STEP3 && zero)     rel_q   <= 1'b1;
      end
    end
  end

  assign en_o.clk_en  = swap_q ? step2_q : step1_q;
  assign en_o.bus_en  = swap_q ? step1_q : step2_q;
  assign en_o.rst_rel = rel_q;

  // R3, R4: the second step never precedes the first
  a_r3_step_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step2_q |-> step1_q);
  // R9: reset release comes last
  a_r9_rst_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_o.rst_rel |-> (en_o.clk_en && en_o.bus_en));
  // R11: disconnect clears every enable on the next clock
  a_r11_disc_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disc_req_i |=> (!en_o.clk_en && !en_o.bus_en && !en_o.rst_rel));
  // R12: the order choice is frozen while a sequence runs
  a_r12_order_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != S_ISO) |=> $stable(swap_q));
endmodule

// File: rtl/hp_pin_ctl.sv
module hp_pin_ctl
  import hp_slot_pkg::*;
#(
  parameter int NCLK = 7,
  parameter int NSUS = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  slot_en_t        en_i,
  input  logic [NCLK-2:0] clk_sw_en_i,
  output logic [NCLK-1:0] clk_low_o,
  output logic [NCLK-1:0] clk_high_o,
  output logic            ad_hold_o,
  output logic [NSUS-1:0] sus_oe_o,
  output logic [NSUS-1:0] sus_val_o,
  output logic            irq_oe_o,
  output logic            pme_oe_o,
  output logic            rst_val_o
);
  localparam int NDRV = NCLK - 1;

  logic bus_en_q;
  logic bus_first;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bus_en_q <= 1'b0;
    else         bus_en_q <= en_i.bus_en;
  end

  assign bus_first = en_i.bus_en && !bus_en_q;

  for (genvar i = 0; i < NDRV; i++) begin : g_clk
    assign clk_low_o[i]  = clk_sw_en_i[i] && !en_i.clk_en;
    assign clk_high_o[i] = !clk_sw_en_i[i];
  end
  // feedback clock is never forced
  assign clk_low_o[NDRV]  = 1'b0;
  assign clk_high_o[NDRV] = 1'b0;

  for (genvar g = 0; g < NSUS; g++) begin : g_sus
    assign sus_oe_o[g]  = !en_i.bus_en || bus_first;
    assign sus_val_o[g] = en_i.bus_en;

    // R6: the high drive lasts a single clock
    a_r6_one_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sus_oe_o[g] && sus_val_o[g]) |=> !(sus_oe_o[g] && sus_val_o[g]));
  end

  assign ad_hold_o = !en_i.bus_en;
  assign irq_oe_o  = !en_i.bus_en;
  assign pme_oe_o  = !en_i.bus_en;
  assign rst_val_o = en_i.rst_rel;

  // R7: sustained groups tri-state only once the data group is released
  a_r7_ad_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sus_oe_o[0] |-> !ad_hold_o);
  // R9: reset high implies every bus group has left isolation
  a_r9_rst_after_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_val_o |-> (!ad_hold_o && !irq_oe_o && !pme_oe_o));
endmodule

// File: rtl/hp_slot_seq.sv
module hp_slot_seq
  import hp_slot_pkg::*;
#(
  parameter int DLY_W = 16,
  parameter int NCLK  = 7,
  parameter int NSUS  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pwr_good_i,
  input  logic             disc_req_i,
  input  logic             swap_order_i,
  input  logic [DLY_W-1:0] dly_step1_i,
  input  logic [DLY_W-1:0] dly_step2_i,
  input  logic [DLY_W-1:0] dly_step3_i,
  input  logic [NCLK-2:0]  clk_sw_en_i,
  input  logic             tx_req_i,
  output logic             tx_fwd_o,
  output logic             tx_abort_o,
  output logic [NCLK-1:0]  clk_low_o,
  output logic [NCLK-1:0]  clk_high_o,
  output logic             ad_hold_o,
  output logic [NSUS-1:0]  sus_oe_o,
  output logic [NSUS-1:0]  sus_val_o,
  output logic             irq_oe_o,
  output logic             pme_oe_o,
  output logic             rst_val_o
);
  slot_en_t en;

  hp_seq_fsm #(.DLY_W(DLY_W)) i_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pwr_good_i   (pwr_good_i),
    .disc_req_i   (disc_req_i),
    .swap_order_i (swap_order_i),
    .dly_step1_i  (dly_step1_i),
    .dly_step2_i  (dly_step2_i),
    .dly_step3_i  (dly_step3_i),
    .en_o         (en)
  );

  hp_pin_ctl #(.NCLK(NCLK), .NSUS(NSUS)) i_pins (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en),
    .clk_sw_en_i (clk_sw_en_i),
    .clk_low_o   (clk_low_o),
    .clk_high_o  (clk_high_o),
    .ad_hold_o   (ad_hold_o),
    .sus_oe_o    (sus_oe_o),
    .sus_val_o   (sus_val_o),
    .irq_oe_o    (irq_oe_o),
    .pme_oe_o    (pme_oe_o),
    .rst_val_o   (rst_val_o)
  );

  // abort gate: open only after reset release
  assign tx_fwd_o   = tx_req_i && en.rst_rel;
  assign tx_abort_o = tx_req_i && !en.rst_rel;

  // R10: forwarding only toward a slot whose reset pin is high
  a_r10_fwd_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_fwd_o |-> rst_val_o);
  // R10: a request is either forwarded or aborted
  a_r10_one_outcome: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_req_i |-> (tx_fwd_o != tx_abort_o));
endmodule

// File: tb/test_hp_slot_seq.sv
module test_hp_slot_seq;
  localparam int DLY_W = 16;
  localparam int NCLK  = 7;
  localparam int NSUS  = 3;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             pwr_good = 1'b0, disc_req = 1'b0, swap_order = 1'b0;
  logic [DLY_W-1:0] d1 = '0, d2 = '0, d3 = '0;
  logic [NCLK-2:0]  sw_en = '1;
  logic             tx_req = 1'b0;
  logic             tx_fwd, tx_abort;
  logic [NCLK-1:0]  clk_low, clk_high;
  logic             ad_hold, irq_oe, pme_oe, rst_val;
  logic [NSUS-1:0]  sus_oe, sus_val;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  hp_slot_seq #(.DLY_W(DLY_W), .NCLK(NCLK), .NSUS(NSUS)) i_hp_slot_seq (
    .clk_i(clk), .rst_ni(rst_n), .pwr_good_i(pwr_good), .disc_req_i(disc_req),
    .swap_order_i(swap_order), .dly_step1_i(d1), .dly_step2_i(d2), .dly_step3_i(d3),
    .clk_sw_en_i(sw_en), .tx_req_i(tx_req), .tx_fwd_o(tx_fwd), .tx_abort_o(tx_abort),
    .clk_low_o(clk_low), .clk_high_o(clk_high), .ad_hold_o(ad_hold),
    .sus_oe_o(sus_oe), .sus_val_o(sus_val), .irq_oe_o(irq_oe), .pme_oe_o(pme_oe),
    .rst_val_o(rst_val)
  );

  function automatic logic [23:0] exp_pins(bit ce, bit be, bit pulse, bit re,
                                           logic [NCLK-2:0] m);
    logic [NCLK-1:0] lo, hi;
    lo = '0; hi = '0;
    for (int i = 0; i < NCLK-1; i++) begin
      lo[i] = m[i] & ~ce;
      hi[i] = ~m[i];
    end
    return {lo, hi, ~be, {3{~be | pulse}}, {3{be}}, ~be, ~be, re};
  endfunction

  function automatic logic [23:0] act_pins();
    return {clk_low, clk_high, ad_hold, sus_oe, sus_val, irq_oe, pme_oe, rst_val};
  endfunction

  task automatic check_pins(string tag, logic [23:0] e);
    n_tests++;
    if (act_pins() !== e) begin
      n_fail++;
      $display("FAIL %s pins act=%h exp=%h t=%0t", tag, act_pins(), e, $time);
    end
  endtask

  task automatic check_tx(bit linked);
    tx_req = $urandom_range(0, 1);
    #1;
    n_tests++;
    if (tx_fwd !== (tx_req & linked) || tx_abort !== (tx_req & ~linked)) begin
      n_fail++;
      $display("FAIL R10 tx fwd/abort act=%b%b exp=%b%b", tx_fwd, tx_abort,
               tx_req & linked, tx_req & ~linked);
    end
  endtask

  // disconnect and return to isolation, checked one clock later (R11)
  task automatic go_iso(bit hold_pg);
    disc_req = 1'b1;
    pwr_good = hold_pg;
    @(negedge clk);
    check_pins("R11 R1 disconnect", exp_pins(0, 0, 0, 0, sw_en));
    if (hold_pg) begin
      repeat (3) begin
        @(negedge clk);
        check_pins("R11 disconnect priority", exp_pins(0, 0, 0, 0, sw_en));
      end
    end
    pwr_good = 1'b0;
    disc_req = 1'b0;
    @(negedge clk);
    check_pins("R1 isolated", exp_pins(0, 0, 0, 0, sw_en));
  endtask

  // one connect sequence; disc_at < 0 runs to completion
  task automatic run_seq(int a, int b, int c, bit ord, logic [NCLK-2:0] m,
                         bit flip, int disc_at);
    int t1, t2, t3, tb, tc, kend;
    bit ce, be, re;
    @(negedge clk);
    sw_en = m; d1 = DLY_W'(a); swap_order = ord;
    @(negedge clk);
    check_pins("R2 before power", exp_pins(0, 0, 0, 0, m));
    pwr_good = 1'b1;
    @(posedge clk);  // E0 samples power good
    #1;
    d1 = $urandom; // later changes of step 1 count must not matter
    d2 = DLY_W'(b); d3 = DLY_W'(c);
    if (flip) swap_order = ~ord;
    t1 = a + 1; t2 = a + b + 2; t3 = a + b + c + 3;
    tb = ord ? t1 : t2;
    tc = ord ? t2 : t1;
    kend = (disc_at >= 0) ? disc_at : t3 + 2;
    for (int k = 0; k <= kend; k++) begin
      @(negedge clk);
      if (k == t1) d2 = $urandom;  // loaded already
      if (k == t2) d3 = $urandom;
      ce = (k >= tc); be = (k >= tb); re = (k >= t3);
      check_pins(ord ? "R4 R12 R5 R6 R7 R8 R9 swapped" : "R2 R3 R12 R5 R6 R7 R8 R9 default",
                 exp_pins(ce, be, be && (k == tb), re, m));
      check_tx(re);
    end
    tx_req = 1'b0;
    go_iso(disc_at == -2);
  endtask

  initial begin
    void'($urandom(32'd20240517));
    #20;
    @(negedge clk);
    check_pins("R1 reset", exp_pins(0, 0, 0, 0, sw_en));
    rst_n = 1'b1;
    @(negedge clk);
    check_pins("R1 after reset", exp_pins(0, 0, 0, 0, sw_en));
    check_tx(0);
    tx_req = 1'b0;

    // power good with disconnect held stays isolated (R11)
    pwr_good = 1'b1; disc_req = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check_pins("R11 disc over power", exp_pins(0, 0, 0, 0, sw_en));
    end
    pwr_good = 1'b0; disc_req = 1'b0;

    run_seq(2, 3, 4, 0, '1, 0, -1);
    run_seq(2, 3, 4, 1, 6'b101101, 0, -1);
    run_seq(0, 0, 0, 0, 6'b010010, 0, -1);
    run_seq(0, 0, 0, 1, '1, 0, -2);
    run_seq(3, 1, 2, 0, '1, 1, -1);       // R12 flip mid-sequence
    run_seq(3, 1, 2, 1, 6'b110011, 1, -1);
    // disconnect landing on step expiry cycles (R11)
    run_seq(4, 4, 4, 0, '1, 0, 4);        // disc set the cycle before clock enable
    run_seq(4, 4, 4, 0, '1, 0, 5);        // right after clock enable
    run_seq(4, 4, 4, 1, '1, 0, 9);        // cycle before second step
    run_seq(4, 4, 4, 0, '1, 0, 14);       // cycle before reset release
    run_seq(2, 2, 2, 0, '1, 0, 20);       // long after live

    for (int r = 0; r < 12; r++) begin
      int da, db, dc, dis;
      da = $urandom_range(0, 15);
      db = $urandom_range(0, 15);
      dc = $urandom_range(0, 15);
      dis = ($urandom_range(0, 2) == 0) ? $urandom_range(0, da + db + dc + 4) : -1;
      run_seq(da, db, dc, 1'($urandom_range(0, 1)), 6'($urandom),
              1'($urandom_range(0, 1)), dis);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule